// File: doc/BRIEF.md
# Converter Result Register Arbiter

This block is the digital control shell around a successive-approximation converter. It holds the run and power-up bits, the conversion-time select field, the channel select, the port-configuration field and a temperature-sensor control byte, all of which the CPU sets over a simple register bus. When the converter reports a finished conversion, the block stores the result in a 10-bit result register. It also sets a sticky end-of-conversion flag that drives the interrupt line.

The main job of the block is to settle what happens when a converter result arrives in the same cycle as CPU bus traffic. If the result register is being read in that cycle, the read returns the old value. The new result waits in a one-entry pending slot and is written on the next cycle that has no result read. If a configuration register is being written in that cycle, the result is thrown away and the flag is not set. For the two temperature-sensor channels, the block also counts conversions since the last restart and marks the early results, which are not settled yet, as invalid.

Results come in on a valid/ready pair. `cnv_ready` is high only while the block is both running and powered. A beat is taken in every cycle where `cnv_valid` and `cnv_ready` are both high. A beat offered while `cnv_ready` is low is dropped, so the converter must hold off instead of waiting. There is no other back-pressure: the pending slot absorbs results that collide with a read.

Top module: `adc_result_arbiter`

## Requirements
- R1: Register map by 3-bit address: 0 mode, 1 channel select (bits 3:0), 2 port config (bits 3:0), 3 sensor control, 4 result (bits 9:0), 5 result upper view (result bits 9:2 on bits 7:0), 6 status. In the mode register, bit 0 is run, bit 1 is power-up and bits 6:2 are the conversion-time field. A read with `bus_rd` returns the addressed value on `bus_rdata` from the clock edge that samples it, and the value is held until the next read.
- R2: A result taken in the same cycle as a read of address 4 or 5 does not change that read, which returns the old value. The result is written on the next cycle with no read of address 4 or 5, and the status flag is set in that same cycle.
- R3: A second result taken while an earlier one is still pending replaces it. Only the later value reaches the result register.
- R4: A result taken in the same cycle as a write to address 0, 1 or 2 is discarded and does not set the flag. The configuration write itself still takes effect.
- R5: A write to address 0 changes the conversion-time field only if run was 0 before the write. Otherwise the field keeps its old value.
- R6: Status bit 0 is the sticky end-of-conversion flag, and `irq` mirrors it. Writing address 6 with bit 0 set clears the flag. A write that would raise run from 0 to 1 leaves run at 0 while the flag is set.
- R7: `cnv_ready` is run AND power-up. A beat offered while it is low leaves the result and the flag unchanged. Writing 0 to both run and power-up brings the block to idle with `cnv_ready` low.
- R8: With channel 8 selected (temperature sensor 0), status bit 1 reads 0 for the first result after a restart and 1 from the second onward.
- R9: With channel 9 selected (temperature sensor 1), status bit 1 reads 0 for the first two results after a restart and 1 from the third onward. For any other channel it reads 1.
- R10: The sensor result count restarts when run rises or when a write changes the channel select.
- R11: Bits 6:4 of the sensor control register always read 0, whatever is written to them. Bits 7 and 3:0 read back as written.
- R12: Reset clears every register, the pending slot, the flag, `irq`, `cnv_ready` and `bus_rdata`.
- R13: A result taken with no conflict appears at address 4 right after the edge that takes it. Address 5 shows its upper 8 bits, and the flag is set on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cnv_valid | input | 1 | Converter result valid |
| cnv_data | input | 10 | Converter result |
| cnv_ready | output | 1 | Block accepts results |
| cnv_chan | output | 4 | Selected channel to converter |
| cnv_tsel | output | 5 | Conversion-time select to converter |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
A pending slot stuck full or stuck empty shows within one cycle of the next read-free bus cycle: either the result register lags by one conversion or a deferred value never appears, and `irq` stays low when it should rise. A wrong sensor counter shows in status bit 1 on the very next result from channel 8 or 9. A conversion-time field changed while running shows up at once on `cnv_tsel` and on the mode readback. Each of these is caught by a read or a port sample one or two cycles after the stimulus.

// File: rtl/adcra_pkg.sv
package adcra_pkg;
  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_CHAN = 3'd1,
    A_PCFG = 3'd2,
    A_TCTL = 3'd3,
    A_RES  = 3'd4,
    A_RESH = 3'd5,
    A_STAT = 3'd6
  } reg_addr_e;

  localparam int MODE_RUN_B   = 0;
  localparam int MODE_PWR_B   = 1;
  localparam int MODE_TSEL_LO = 2;
  localparam int STAT_FLAG_B  = 0;
  localparam int STAT_OK_B    = 1;
  localparam logic [7:0] TCTL_KEEP = 8'h8F;
endpackage

// File: rtl/adcra_cfg.sv
module adcra_cfg
  import adcra_pkg::*;
#(
  parameter int WD_W = 8,
  parameter int CH_W = 4,
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2:0]      addr,
  input  logic [WD_W-1:0] wdata,
  input  logic            flag,
  output logic            run_q,
  output logic            pwr_q,
  output logic [TS_W-1:0] tsel_q,
  output logic [CH_W-1:0] chan_q,
  output logic [CH_W-1:0] pcfg_q,
  output logic [7:0]      tctl_q,
  output logic            cfg_wr,
  output logic            cnt_restart
);
  logic wr_mode, wr_chan, wr_pcfg, wr_tctl, run_rise;

  assign wr_mode = wr && (addr == A_MODE);
  assign wr_chan = wr && (addr == A_CHAN);
  assign wr_pcfg = wr && (addr == A_PCFG);
  assign wr_tctl = wr && (addr == A_TCTL);
  assign cfg_wr  = wr_mode || wr_chan || wr_pcfg;

  // run may only rise while no end-of-conversion flag is outstanding
  assign run_rise    = wr_mode && !run_q && wdata[MODE_RUN_B] && !flag;
  assign cnt_restart = run_rise || (wr_chan && (wdata[CH_W-1:0] != chan_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pwr_q  <= 1'b0;
      tsel_q <= '0;
      chan_q <= '0;
      pcfg_q <= '0;
      tctl_q <= '0;
    end else begin
      if (wr_mode) begin
        pwr_q <= wdata[MODE_PWR_B];
        if (!run_q) tsel_q <= wdata[MODE_TSEL_LO +: TS_W];
        run_q <= run_q ? wdata[MODE_RUN_B] : run_rise;
      end
      if (wr_chan) chan_q <= wdata[CH_W-1:0];
      if (wr_pcfg) pcfg_q <= wdata[CH_W-1:0];
      if (wr_tctl) tctl_q <= wdata[7:0] & TCTL_KEEP;
    end
  end

  assert_tsel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(tsel_q));
  assert_run_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !$past(flag));
endmodule

// File: rtl/adcra_tsense.sv
module adcra_tsense #(
  parameter int CH_W = 4,
  parameter logic [CH_W-1:0] TS0_CH = 4'd8,
  parameter logic [CH_W-1:0] TS1_CH = 4'd9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            acc,
  input  logic [CH_W-1:0] chan,
  output logic            ok_now
);
  localparam logic [1:0] CNT_TOP = 2'd2;
  logic [1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (restart)                 cnt_q <= '0;
    else if (acc && cnt_q != CNT_TOP) cnt_q <= cnt_q + 2'd1;
  end

  // cnt_q counts earlier results since the restart
  always_comb begin
    if (chan == TS0_CH)      ok_now = (cnt_q >= 2'd1);
    else if (chan == TS1_CH) ok_now = (cnt_q >= 2'd2);
    else                     ok_now = 1'b1;
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_TOP) |=> (cnt_q == CNT_TOP) || (cnt_q == 2'd0));
endmodule

// File: rtl/adcra_result.sv
module adcra_result #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [RES_W-1:0] data,
  input  logic             ok_in,
  input  logic             cfg_wr,
  input  logic             rd_res,
  input  logic             clr_flag,
  output logic [RES_W-1:0] result_q,
  output logic             ok_q,
  output logic             flag_q,
  output logic             pend_q
);
  logic [RES_W-1:0] pdata_q;
  logic             pok_q, take, commit;

  assign take   = acc && !cfg_wr;                     // config write drops result
  assign commit = (take && !rd_res) || (pend_q && !rd_res);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      ok_q     <= 1'b0;
      pend_q   <= 1'b0;
      pdata_q  <= '0;
      pok_q    <= 1'b0;
    end else if (take && rd_res) begin
      pend_q  <= 1'b1;
      pdata_q <= data;
      pok_q   <= ok_in;
    end else if (take) begin
      result_q <= data;
      ok_q     <= ok_in;
      pend_q   <= 1'b0;
    end else if (pend_q && !rd_res) begin
      result_q <= pdata_q;
      ok_q     <= pok_q;
      pend_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= commit || (flag_q && !clr_flag);
  end

  assert_defer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cfg_wr && rd_res) |=> (pend_q && $stable(result_q)));
  assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rd_res) |=> !pend_q);
  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg_wr && !pend_q) |=> ($stable(result_q) && !pend_q && !$rose(flag_q)));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_flag) |=> flag_q);
endmodule

// File: rtl/adc_result_arbiter.sv
module adc_result_arbiter
  import adcra_pkg::*;
#(
  parameter int WD_W  = 8,
  parameter int RD_W  = 16,
  parameter int RES_W = 10,
  parameter int CH_W  = 4,
  parameter int TS_W  = 5,
  parameter logic [CH_W-1:0] TS0_CH = 4'd8,
  parameter logic [CH_W-1:0] TS1_CH = 4'd9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [WD_W-1:0]  bus_wdata,
  output logic [RD_W-1:0]  bus_rdata,
  input  logic             cnv_valid,
  input  logic [RES_W-1:0] cnv_data,
  output logic             cnv_ready,
  output logic [CH_W-1:0]  cnv_chan,
  output logic [TS_W-1:0]  cnv_tsel,
  output logic             irq
);
  localparam int HI_W = 8;

  logic             run, pwr, flag, pend, ok_res, ok_now, cfg_wr, restart;
  logic             acc, rd_res, clr_flag;
  logic [CH_W-1:0]  pcfg;
  logic [7:0]       tctl;
  logic [RES_W-1:0] result;
  logic [RD_W-1:0]  rd_mux;

  assign cnv_ready = run && pwr;
  assign acc       = cnv_valid && cnv_ready;
  assign rd_res    = bus_rd && (bus_addr == A_RES || bus_addr == A_RESH);
  assign clr_flag  = bus_wr && (bus_addr == A_STAT) && bus_wdata[STAT_FLAG_B];
  assign irq       = flag;

  adcra_cfg #(.WD_W(WD_W), .CH_W(CH_W), .TS_W(TS_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .flag(flag), .run_q(run), .pwr_q(pwr), .tsel_q(cnv_tsel), .chan_q(cnv_chan),
    .pcfg_q(pcfg), .tctl_q(tctl), .cfg_wr(cfg_wr), .cnt_restart(restart));

  adcra_tsense #(.CH_W(CH_W), .TS0_CH(TS0_CH), .TS1_CH(TS1_CH)) ts_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .acc(acc), .chan(cnv_chan),
    .ok_now(ok_now));

  adcra_result #(.RES_W(RES_W)) res_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .data(cnv_data), .ok_in(ok_now),
    .cfg_wr(cfg_wr), .rd_res(rd_res), .clr_flag(clr_flag), .result_q(result),
    .ok_q(ok_res), .flag_q(flag), .pend_q(pend));

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_MODE: begin
        rd_mux[MODE_RUN_B]              = run;
        rd_mux[MODE_PWR_B]              = pwr;
        rd_mux[MODE_TSEL_LO +: TS_W]    = cnv_tsel;
      end
      A_CHAN: rd_mux[CH_W-1:0]  = cnv_chan;
      A_PCFG: rd_mux[CH_W-1:0]  = pcfg;
      A_TCTL: rd_mux[7:0]       = tctl;
      A_RES:  rd_mux[RES_W-1:0] = result;
      A_RESH: rd_mux[HI_W-1:0]  = result[RES_W-1 -: HI_W];
      A_STAT: begin
        rd_mux[STAT_FLAG_B] = flag;
        rd_mux[STAT_OK_B]   = ok_res;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_tctl_rsvd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_TCTL) |=> (bus_rdata[6:4] == 3'b000));
  assert_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_valid && !cnv_ready && !pend) |=> ($stable(result) && !$rose(flag)));
endmodule

// File: tb/adc_result_arbiter_tb_top.sv
`timescale 1ns/1ps
module adc_result_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, cnv_valid = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [9:0]  cnv_data = '0;
  logic [15:0] bus_rdata;
  logic        cnv_ready, irq;
  logic [3:0]  cnv_chan;
  logic [4:0]  cnv_tsel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_result_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnv_valid(cnv_valid),
    .cnv_data(cnv_data), .cnv_ready(cnv_ready), .cnv_chan(cnv_chan),
    .cnv_tsel(cnv_tsel), .irq(irq));

  localparam logic [2:0] MO = 3'd0, CH = 3'd1, PC = 3'd2, TC = 3'd3,
                         RS = 3'd4, RH = 3'd5, ST = 3'd6;
  // op: 0 write, 1 read and compare, 2 converter beat
  localparam int NV = 22;
  localparam logic [40:0] VEC [NV] = '{
    {2'd1, MO, 16'h0000, 16'h0000, 4'd12},  // R12 mode after reset
    {2'd1, ST, 16'h0000, 16'h0000, 4'd12},  // R12 status after reset
    {2'd0, MO, 16'h0056, 16'h0000, 4'd1},
    {2'd1, MO, 16'h0000, 16'h0056, 4'd1},   // R1 mode readback
    {2'd0, TC, 16'h00FF, 16'h0000, 4'd11},
    {2'd1, TC, 16'h0000, 16'h008F, 4'd11},  // R11 reserved bits read 0
    {2'd0, CH, 16'h0003, 16'h0000, 4'd1},
    {2'd0, PC, 16'h000A, 16'h0000, 4'd1},
    {2'd1, PC, 16'h0000, 16'h000A, 4'd1},   // R1 port config readback
    {2'd0, MO, 16'h0057, 16'h0000, 4'd5},
    {2'd0, MO, 16'h0007, 16'h0000, 4'd5},
    {2'd1, MO, 16'h0000, 16'h0057, 4'd5},   // R5 time field kept while running
    {2'd2, MO, 16'h02A5, 16'h0000, 4'd13},
    {2'd1, RS, 16'h0000, 16'h02A5, 4'd13},  // R13 result view
    {2'd1, RH, 16'h0000, 16'h00A9, 4'd13},  // R13 upper view
    {2'd1, ST, 16'h0000, 16'h0003, 4'd13},  // R13 flag set, ok for plain channel
    {2'd0, ST, 16'h0001, 16'h0000, 4'd6},
    {2'd1, ST, 16'h0000, 16'h0002, 4'd6},   // R6 flag cleared
    {2'd0, MO, 16'h0056, 16'h0000, 4'd7},
    {2'd2, MO, 16'h0111, 16'h0000, 4'd7},
    {2'd1, RS, 16'h0000, 16'h02A5, 4'd7},   // R7 beat ignored while not ready
    {2'd1, ST, 16'h0000, 16'h0002, 4'd7}    // R7 no flag
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic [2:0] a,
                       input logic [7:0] wd, input logic cv, input logic [9:0] cd);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    cnv_valid = cv; cnv_data = cd;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    cnv_valid = 1'b0; cnv_data = '0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    drive(1'b1, 1'b0, a, d, 1'b0, '0);
  endtask
  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    drive(1'b0, 1'b1, a, '0, 1'b0, '0);
    chk(req, bus_rdata, exp);
  endtask
  task automatic beat(input logic [9:0] d);
    drive(1'b0, 1'b0, '0, '0, 1'b1, d);
  endtask
  task automatic idle();
    drive(1'b0, 1'b0, '0, '0, 1'b0, '0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 irq", {15'b0, irq}, 16'h0);
    chk("R12 ready", {15'b0, cnv_ready}, 16'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [2:0]  a;
      logic [15:0] d, e;
      logic [3:0]  rq;
      op = VEC[i][40:39]; a = VEC[i][38:36]; d = VEC[i][35:20];
      e = VEC[i][19:4]; rq = VEC[i][3:0];
      case (op)
        2'd0: wr_reg(a, d[7:0]);
        2'd1: rd_chk(a, e, $sformatf("R%0d vec%0d", rq, i));
        default: beat(d[9:0]);
      endcase
    end

    // R6: run cannot rise while the flag is set
    wr_reg(MO, 8'h57); beat(10'h100);
    wr_reg(MO, 8'h56); wr_reg(MO, 8'h57);
    rd_chk(MO, 16'h0056, "R6 start blocked");
    wr_reg(ST, 8'h01); wr_reg(MO, 8'h57);
    rd_chk(MO, 16'h0057, "R6 start accepted");

    // R8: sensor 0 channel
    wr_reg(CH, 8'h08); beat(10'h010);
    rd_chk(ST, 16'h0001, "R8 first invalid");
    wr_reg(ST, 8'h01); beat(10'h011);
    rd_chk(ST, 16'h0003, "R8 second valid");
    wr_reg(ST, 8'h01);
    // R9 and R10: channel change restarts the count
    wr_reg(CH, 8'h09); beat(10'h012);
    rd_chk(ST, 16'h0001, "R9 R10 first invalid");
    wr_reg(ST, 8'h01); beat(10'h013);
    rd_chk(ST, 16'h0001, "R9 second invalid");
    wr_reg(ST, 8'h01); beat(10'h014);
    rd_chk(ST, 16'h0003, "R9 third valid");
    wr_reg(ST, 8'h01);
    // R10: run rise restarts the count
    wr_reg(MO, 8'h56); wr_reg(MO, 8'h57); beat(10'h123);
    rd_chk(ST, 16'h0001, "R10 restart on run");
    wr_reg(ST, 8'h01);

    // R2: read collides with result
    drive(1'b0, 1'b1, RS, '0, 1'b1, 10'h3C0);
    chk("R2 old value read", bus_rdata, 16'h0123);
    chk("R2 irq held back", {15'b0, irq}, 16'h0);
    idle();
    chk("R2 irq after drain", {15'b0, irq}, 16'h1);
    rd_chk(RS, 16'h03C0, "R2 new value");
    wr_reg(ST, 8'h01);
    // R3: upper view collision, pending overwritten
    drive(1'b0, 1'b1, RH, '0, 1'b1, 10'h0F0);
    chk("R2 upper old value", bus_rdata, 16'h00F0);
    drive(1'b0, 1'b1, RH, '0, 1'b1, 10'h2C4);
    chk("R3 still old", bus_rdata, 16'h00F0);
    chk("R3 irq held", {15'b0, irq}, 16'h0);
    idle();
    rd_chk(RS, 16'h02C4, "R3 later value wins");
    wr_reg(ST, 8'h01);

    // R4: config write collides with result
    drive(1'b1, 1'b0, PC, 8'h05, 1'b1, 10'h3FF);
    idle();
    chk("R4 no irq", {15'b0, irq}, 16'h0);
    rd_chk(RS, 16'h02C4, "R4 result dropped");
    rd_chk(PC, 16'h0005, "R4 write kept");
    drive(1'b1, 1'b0, MO, 8'h57, 1'b1, 10'h001);
    idle();
    chk("R4 mode no irq", {15'b0, irq}, 16'h0);
    rd_chk(RS, 16'h02C4, "R4 mode drop");

    // R7 and R5: idle state, field change allowed when stopped
    wr_reg(MO, 8'h56); wr_reg(MO, 8'h00);
    chk("R7 idle ready low", {15'b0, cnv_ready}, 16'h0);
    chk("R5 tsel port", {11'b0, cnv_tsel}, 16'h0);
    rd_chk(MO, 16'h0000, "R5 field changed when stopped");

    // R12: reset mid-run
    wr_reg(MO, 8'h57); beat(10'h0AA);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R12 irq cleared", {15'b0, irq}, 16'h0);
    chk("R12 ready cleared", {15'b0, cnv_ready}, 16'h0);
    chk("R12 rdata cleared", bus_rdata, 16'h0);
    @(negedge clk) rst_n = 1'b1;
    rd_chk(RS, 16'h0000, "R12 result cleared");
    rd_chk(MO, 16'h0000, "R12 mode cleared");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule